// File: doc/BRIEF.md
# Keepalive Frequency-Window Watchdog

This block guards a motor enable line with a slow heartbeat. A nominal 50 Hz keepalive square wave arrives asynchronously. The block resynchronizes it into the single 1 MHz system clock domain and finds its rising edges. It then measures the spacing between consecutive rising edges in units of a 10 kHz timebase. That timebase is a one-cycle enable pulse made by a divide-by-100 prescaler. It is never a clock, so every register in the block toggles on the same 1 MHz edge.

The enable output is granted only while the heartbeat stays inside a ±10% frequency window. A window in ticks of 182 to 222, both inclusive, covers roughly 45 Hz to 55 Hz. A period that is too short or too long drops the enable. A missing heartbeat is caught by a timeout as soon as the tick count passes the upper limit, so a dead input does not have to wait for a further edge. After any fault, and after reset, the enable returns only after a run of consecutive valid periods. A single good edge therefore cannot restart the motor.

Top module: `keepalive_watchdog`

## Requirements
- R1: While reset is high, and from reset until the re-enable condition of R5 is first met, `motor_en_o` is 0.
- R2: A period ending at a rising edge is valid when its length in timebase ticks is between MIN_TICKS and MAX_TICKS inclusive. A period of exactly N*PRESCALE clock cycles measures N ticks.
- R3: The timebase is a single-cycle pulse that repeats every PRESCALE clock cycles. All state is clocked by `clk` alone.
- R4: `keepalive_i` passes through SYNC_STAGES flip-flops before use. Only its rising edges are measured, so the position of the falling edge has no effect on the result. The enable reacts to a rising edge within 4 clock cycles.
- R5: `motor_en_o` rises after GOOD_NEEDED consecutive valid periods. The first rising edge after reset or after a loss of signal only starts a measurement and never counts as valid.
- R6: A period shorter than MIN_TICKS or longer than MAX_TICKS clears `motor_en_o` and the streak of valid periods, so GOOD_NEEDED new valid periods are needed again.
- R7: If MAX_TICKS+1 ticks pass with no rising edge, `motor_en_o` falls at once, before any further edge arrives.
- R8: The period counter saturates at MAX_TICKS+1 and never wraps. A gap long enough that a wrapped count would land inside the window is still judged invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (1 MHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| keepalive_i | input | 1 | Asynchronous heartbeat input |
| motor_en_o | output | 1 | Registered motor enable, high while the heartbeat is valid |

## Verification
The bench probes the exact window edges: periods of MIN_TICKS and MAX_TICKS must keep the enable, and periods one tick outside them must drop it. A design with an off-by-one in its compare, or one that loses the tick landing on the edge cycle, would fail these. The silent-input case is checked twice. The enable must fall roughly MAX_TICKS+1 ticks after the last edge, not at the next edge. A gap whose wrapped count would alias to a valid period must still be judged bad, which catches a wrapping counter. Restart is checked edge by edge, so a design that re-enables on the first good edge, or that counts the opening edge as a period, is caught. Varied duty cycles show that falling edges play no part.

// File: rtl/kw_pkg.sv
package kw_pkg;
  // Verdict produced by the period meter, one pulse per event
  typedef struct packed {
    logic good;   // period ended inside the window
    logic bad;    // period ended outside the window
    logic lost;   // no edge within the maximum window
  } kw_event_t;
endpackage

// File: rtl/kw_tick_gen.sv
module kw_tick_gen #(
  parameter int PRESCALE = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else if (div_q == LAST) begin
      div_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/kw_sync_edge.sv
module kw_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[SYNC_STAGES-1];
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/kw_period_meter.sv
module kw_period_meter
  import kw_pkg::*;
#(
  parameter int MIN_TICKS = 182,
  parameter int MAX_TICKS = 222
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      rise_i,
  output kw_event_t ev_o,
  output logic [$clog2(MAX_TICKS+2)-1:0] count_o
);
  localparam int CNT_W = $clog2(MAX_TICKS + 2);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] LO   = CNT_W'(MIN_TICKS);
  localparam logic [CNT_W-1:0] HI   = CNT_W'(MAX_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] meas;
  logic             can_step;
  logic             in_window;

  // A tick landing on the edge cycle still belongs to the closing period
  always_comb begin
    can_step  = tick_i && (cnt_q != SAT);
    meas      = can_step ? cnt_q + 1'b1 : cnt_q;
    in_window = (meas >= LO) && (meas <= HI);
  end

  // Reset loads the saturated value: the first edge is never judged valid
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= SAT;
      ev_o  <= '0;
    end else begin
      ev_o <= '0;
      if (rise_i) begin
        ev_o.good <= in_window;
        ev_o.bad  <= ~in_window;
        cnt_q     <= '0;
      end else if (can_step) begin
        cnt_q     <= cnt_q + 1'b1;
        ev_o.lost <= (cnt_q + 1'b1) == SAT;
      end
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/kw_qualifier.sv
module kw_qualifier
  import kw_pkg::*;
#(
  parameter int GOOD_NEEDED = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  kw_event_t ev_i,
  output logic      en_o
);
  localparam int GOOD_W = $clog2(GOOD_NEEDED + 1);
  localparam logic [GOOD_W-1:0] LIM = GOOD_W'(GOOD_NEEDED);

  logic [GOOD_W-1:0] streak_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      streak_q <= '0;
      en_o     <= 1'b0;
    end else if (ev_i.bad || ev_i.lost) begin
      streak_q <= '0;
      en_o     <= 1'b0;
    end else if (ev_i.good) begin
      if (streak_q != LIM) streak_q <= streak_q + 1'b1;
      if (streak_q >= LIM - 1'b1) en_o <= 1'b1;
    end
  end
endmodule

// File: rtl/keepalive_watchdog.sv
module keepalive_watchdog
  import kw_pkg::*;
#(
  parameter int PRESCALE    = 100,
  parameter int MIN_TICKS   = 182,
  parameter int MAX_TICKS   = 222,
  parameter int GOOD_NEEDED = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic keepalive_i,
  output logic motor_en_o
);
  localparam int CNT_W = $clog2(MAX_TICKS + 2);

  logic             tick;
  logic             rise;
  kw_event_t        ev;
  logic [CNT_W-1:0] period_cnt;

  kw_tick_gen #(.PRESCALE(PRESCALE)) tick_i (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  kw_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_i(keepalive_i), .rise_o(rise)
  );

  kw_period_meter #(.MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS)) meter_i (
    .clk(clk), .rst(rst), .tick_i(tick), .rise_i(rise),
    .ev_o(ev), .count_o(period_cnt)
  );

  kw_qualifier #(.GOOD_NEEDED(GOOD_NEEDED)) qual_i (
    .clk(clk), .rst(rst), .ev_i(ev), .en_o(motor_en_o)
  );
endmodule

// File: rtl/keepalive_watchdog_chk.sv
module keepalive_watchdog_chk #(
  parameter int PRESCALE  = 100,
  parameter int MAX_TICKS = 222
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic good,
  input logic bad,
  input logic lost,
  input logic [$clog2(MAX_TICKS+2)-1:0] cnt,
  input logic en
);
  localparam int GAP_W = $clog2(PRESCALE + 1);
  localparam int CNT_W = $clog2(MAX_TICKS + 2);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_W'(PRESCALE)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && seen_q) |-> (gap_q == GAP_W'(PRESCALE - 1)));

  assert_reset_off_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !en);

  assert_verdict_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(good && bad));

  assert_rise_on_good_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> $past(good));

  assert_bad_drops_R6: assert property (@(posedge clk) disable iff (rst)
    bad |=> !en);

  assert_lost_drops_R7: assert property (@(posedge clk) disable iff (rst)
    lost |=> !en);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_TICKS + 1));
endmodule

bind keepalive_watchdog keepalive_watchdog_chk #(
  .PRESCALE(PRESCALE), .MAX_TICKS(MAX_TICKS)
) chk_i (
  .clk(clk), .rst(rst), .tick(tick),
  .good(ev.good), .bad(ev.bad), .lost(ev.lost),
  .cnt(period_cnt), .en(motor_en_o)
);

// File: tb/keepalive_watchdog_tb.sv
module keepalive_watchdog_tb_top;
  localparam int PS   = 5;
  localparam int MINT = 18;
  localparam int MAXT = 22;
  localparam int GOOD = 3;
  localparam int NOM  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ka  = 1'b0;
  logic en;

  int errors = 0;
  int checks = 0;
  int last_n = 1000;   // nothing measured yet: first edge is invalid
  int streak = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  keepalive_watchdog #(
    .PRESCALE(PS), .MIN_TICKS(MINT), .MAX_TICKS(MAXT),
    .GOOD_NEEDED(GOOD), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .keepalive_i(ka), .motor_en_o(en)
  );

  function automatic bit in_window(int n);
    return (n >= MINT) && (n <= MAXT);
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: motor_en_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // One rising edge, then a period of n ticks; high phase lasts hi cycles
  task automatic period(int n, int hi, string tag);
    int total;
    total = n * PS;
    @(negedge clk);
    ka = 1'b1;
    if (in_window(last_n)) streak++;
    else                   streak = 0;
    last_n = n;
    wait_cyc(6);
    check(en, streak >= GOOD, tag);
    if (n >= MAXT + 3) begin
      wait_cyc(MAXT * PS - 6);
      check(en, streak >= GOOD, {tag, " R7 before timeout"});
      wait_cyc(PS + 6);
      check(en, 1'b0, {tag, " R7 after timeout"});
      streak = 0;
      wait_cyc(hi - (MAXT + 1) * PS - 6 > 0 ? hi - (MAXT + 1) * PS - 6 : 0);
      ka = 1'b0;
      wait_cyc(total - 1 - ((hi > (MAXT + 1) * PS + 6) ? hi : (MAXT + 1) * PS + 6));
    end else begin
      wait_cyc(hi - 6);
      ka = 1'b0;
      wait_cyc(total - hi - 1);
    end
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'd1234);
    rst = 1'b1;
    wait_cyc(4);
    check(en, 1'b0, "R1 in reset");
    rst = 1'b0;
    wait_cyc(3);
    check(en, 1'b0, "R1 after reset");

    // Start-up: opening edge only arms, then three valid periods
    period(NOM, NOM * PS / 2, "R5 edge1");
    period(NOM, NOM * PS / 2, "R5 edge2");
    period(NOM, NOM * PS / 2, "R5 edge3");
    period(NOM, NOM * PS / 2, "R5 edge4");

    // Window edges R2 R3
    period(MINT, 12, "R2 R3 min");
    period(MAXT, MAXT * PS - 10, "R2 R3 max");
    period(MINT - 1, MINT * PS / 2, "R2 after max");
    period(NOM, NOM * PS / 2, "R6 short period");
    period(NOM, NOM * PS / 2, "R6 recover1");
    period(NOM, NOM * PS / 2, "R6 recover2");
    period(MAXT + 1, NOM * PS / 2, "R6 recover3");
    period(NOM, NOM * PS / 2, "R6 long period");
    period(NOM, 8, "R4 duty short");
    period(NOM, NOM * PS - 8, "R4 duty long");
    // Gap whose wrapped count would alias into the window
    period(52, NOM * PS / 2, "R4 duty restore");
    period(NOM, NOM * PS / 2, "R8 alias gap");
    period(NOM, NOM * PS / 2, "R8 restart1");
    period(NOM, NOM * PS / 2, "R8 restart2");
    period(NOM, NOM * PS / 2, "R8 restart3");

    // Random periods around the window, random duty
    for (int r = 0; r < 40; r++) begin
      int n;
      int hi;
      if (($urandom % 4) == 0) n = MINT - 3 + int'($urandom % (MAXT - MINT + 7));
      else                     n = MINT + int'($urandom % (MAXT - MINT + 1));
      if (($urandom % 16) == 0) n = MAXT + 3 + int'($urandom % 10);
      hi = 8 + int'($urandom % (n * PS - 16));
      period(n, hi, "R2 R5 R6 random");
    end
    period(NOM, NOM * PS / 2, "R6 random tail");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule